// File: doc/BRIEF.md
# Exception Catch Debug Control

This block holds the 32-bit control word that decides which processor exception events become catch debug events. An external debugger reaches the word over a memory-mapped debug bus at byte offset 0x098. For each of four privilege levels and for both the secure and the non-secure world, two bits choose one of four policies: off, returns only, everything, or entries and resets only.

The processor pipeline reports events to the block. Each report carries a valid strobe, the event kind, the target level and the security state. When a valid report matches the programmed policy, the block raises a single-cycle catch pulse on the next clock. Bus access depends on power and lock inputs. When access is not allowed the bus gets an error. When the software lock is set the word is read-only. Otherwise it is read-write.

A parameter selects a reduced variant. In that variant only the eight coarse enable bits exist. Further parameters name the implemented privilege levels and say whether reset entries may be caught.

Top module: `exc_catch_ctl`

## Requirements
- R1: The full variant stores bits [15:0]. Bits [3:0] are the secure coarse enables, [7:4] the non-secure coarse enables, [11:8] the secure return controls and [15:12] the non-secure return controls, with the bit index inside each group equal to the privilege level. Bits [31:16] read as zero and ignore writes.
- R2: When the core is unpowered, or the double lock or the OS lock is set, an access to the register sets `bus_err`. The read data is then zero and a write is dropped.
- R3: When access is allowed and `sw_lock` is 1, reads return the register and writes are ignored without an error.
- R4: Only byte offset 0x098 selects the register. At any other offset, or with `bus_sel` low, `bus_err` and `bus_rdata` are 0 and writes have no effect.
- R5: With coarse bit 0 and return bit 0, no event kind to that level and world fires.
- R6: With coarse bit 0 and return bit 1, only an exception return fires.
- R7: With coarse bit 1 and return bit 0, exception entry, reset entry and exception return all fire.
- R8: With coarse bit 1 and return bit 1, exception entry and reset entry fire and exception return does not.
- R9: In the reduced variant only bits [7:0] exist, bits [31:8] read as zero, and a coarse bit alone enables entry, reset and return for its level and world.
- R10: Event reports that target a level absent from `LVL_IMPL` never fire, whatever the register holds.
- R11: With `RST_CATCH` at 0, reset-entry reports never fire. Event kind encoding: 0 = exception entry, 1 = reset entry, 2 = exception return, 3 = reserved, which never fires.
- R12: `catch_pulse` is high for exactly the one cycle after a clock edge that saw `ev_valid` with a matching report. With no matching report it stays low.
- R13: The cold reset clears the register and the pulse. The warm reset clears only the pulse and leaves the register contents unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| cold_rst_n | input | 1 | Cold reset, asynchronous, active low |
| warm_rst_n | input | 1 | Warm reset, synchronous, active low |
| core_pwr | input | 1 | Core power domain is up |
| dbl_lock | input | 1 | Double lock is set |
| os_lock | input | 1 | OS lock is set |
| sw_lock | input | 1 | Software lock is set |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| bus_err | output | 1 | Error response, valid in the access cycle |
| ev_valid | input | 1 | Event report strobe |
| ev_kind | input | 2 | Event kind (see R11) |
| ev_level | input | 2 | Target privilege level |
| ev_secure | input | 1 | 1 = secure world |
| catch_pulse | output | 1 | Catch debug event pulse |

## Verification
Read data and the error response are combinational, so they are due in the same cycle as the access. A write is visible from the next cycle on. The catch pulse is due one clock edge after the report that causes it. The bench drives inputs just after a falling edge and compares the bus outputs 1 ns later against a model that holds the register contents before the coming edge. It then advances the model at the rising edge and compares the pulse at the following falling edge. The full variant and the reduced variant with reset catching off run side by side on the same stimulus, and each is checked every cycle.

// File: rtl/exc_catch_ctl.sv
module exc_catch_ctl #(
  parameter bit          FULL_CTRL = 1'b1,
  parameter logic [3:0]  LVL_IMPL  = 4'hF,
  parameter bit          RST_CATCH = 1'b1,
  parameter int          ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] REG_OFS = ADDR_W'('h098)
) (
  input  logic              clk,
  input  logic              cold_rst_n,
  input  logic              warm_rst_n,
  input  logic              core_pwr,
  input  logic              dbl_lock,
  input  logic              os_lock,
  input  logic              sw_lock,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_err,
  input  logic              ev_valid,
  input  logic [1:0]        ev_kind,
  input  logic [1:0]        ev_level,
  input  logic              ev_secure,
  output logic              catch_pulse
);
  localparam logic [31:0] WMASK    = FULL_CTRL ? 32'h0000_FFFF : 32'h0000_00FF;
  localparam logic [1:0]  K_ENTRY  = 2'd0;
  localparam logic [1:0]  K_RESET  = 2'd1;
  localparam logic [1:0]  K_RETURN = 2'd2;

  logic [31:0] ctrl_q;
  logic        catch_q;
  logic        ev_hit;

  wire avail = core_pwr && !dbl_lock && !os_lock;
  wire sel   = bus_sel && (bus_addr == REG_OFS);
  wire wr_ok = sel && avail && bus_wr && !sw_lock;

  assign bus_err   = sel && !avail;
  assign bus_rdata = (sel && avail) ? ctrl_q : 32'h0;

  always_ff @(posedge clk or negedge cold_rst_n)
    if (!cold_rst_n)  ctrl_q <= 32'h0;
    else if (wr_ok)   ctrl_q <= bus_wdata & WMASK;

  wire [3:0] coarse_v = ev_secure ? ctrl_q[3:0]  : ctrl_q[7:4];
  wire [3:0] ret_v    = ev_secure ? ctrl_q[11:8] : ctrl_q[15:12];
  wire       lvl_ok   = LVL_IMPL[ev_level];
  wire       c_bit    = coarse_v[ev_level];
  wire       r_bit    = ret_v[ev_level];

  always_comb begin
    unique case (ev_kind)
      K_ENTRY:  ev_hit = lvl_ok && c_bit;
      K_RESET:  ev_hit = lvl_ok && c_bit && RST_CATCH;
      K_RETURN: ev_hit = lvl_ok && (c_bit != r_bit);
      default:  ev_hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge cold_rst_n)
    if (!cold_rst_n)      catch_q <= 1'b0;
    else if (!warm_rst_n) catch_q <= 1'b0;
    else                  catch_q <= ev_valid && ev_hit;

  assign catch_pulse = catch_q;

  // R1
  upper_zero_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    bus_rdata[31:16] == 16'h0);
  // R2
  err_quiet_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    bus_err |-> (bus_rdata == 32'h0));
  // R3
  ro_keep_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (bus_sel && bus_wr && sw_lock) |=> $stable(ctrl_q));
  // R10
  unimpl_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (ev_valid && !LVL_IMPL[ev_level]) |=> !catch_pulse);
  // R11
  rst_off_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (ev_valid && ev_kind == K_RESET && !RST_CATCH) |=> !catch_pulse);
  // R12
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    catch_pulse |-> $past(ev_valid));
  // R13
  warm_keep_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (!warm_rst_n && !bus_sel) |=> ($stable(ctrl_q) && !catch_pulse));
endmodule

// File: tb/test_exc_catch_ctl.sv
module test_exc_catch_ctl;
  localparam logic [3:0] LVLS = 4'b0111;

  logic clk = 0;
  always #2.5 clk = ~clk;

  logic cold_rst_n, warm_rst_n, core_pwr, dbl_lock, os_lock, sw_lock;
  logic bus_sel, bus_wr, ev_valid, ev_secure;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [1:0]  ev_kind, ev_level;
  logic [31:0] rd_f, rd_r;
  logic        err_f, err_r, cp_f, cp_r;

  exc_catch_ctl #(.FULL_CTRL(1'b1), .LVL_IMPL(LVLS), .RST_CATCH(1'b1)) i_exc_catch_ctl (
    .clk, .cold_rst_n, .warm_rst_n, .core_pwr, .dbl_lock, .os_lock, .sw_lock,
    .bus_sel, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata(rd_f), .bus_err(err_f),
    .ev_valid, .ev_kind, .ev_level, .ev_secure, .catch_pulse(cp_f));

  exc_catch_ctl #(.FULL_CTRL(1'b0), .LVL_IMPL(LVLS), .RST_CATCH(1'b0)) i_exc_catch_ctl_rdc (
    .clk, .cold_rst_n, .warm_rst_n, .core_pwr, .dbl_lock, .os_lock, .sw_lock,
    .bus_sel, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata(rd_r), .bus_err(err_r),
    .ev_valid, .ev_kind, .ev_level, .ev_secure, .catch_pulse(cp_r));

  int n_chk = 0, n_fail = 0;
  string cur_req = "R13";
  logic [31:0] m_reg [2];
  bit m_cp [2];

  function automatic bit fires(logic [31:0] r, bit full, bit rst_en,
                               logic [1:0] k, logic [1:0] l, bit s);
    bit co, re;
    if (!LVLS[l]) return 0;
    co = s ? r[l] : r[4 + l];
    re = full ? (s ? r[8 + l] : r[12 + l]) : 1'b0;
    if (k == 2'd0) return co;
    if (k == 2'd1) return rst_en && co;
    if (k == 2'd2) return (co && !re) || (!co && re);
    return 0;
  endfunction

  task automatic check(bit ok, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  task automatic tick();
    bit acc, sel;
    logic [31:0] exp_rd [2];
    bit nx_cp [2];
    logic [31:0] nx_reg [2];
    #1;
    sel = bus_sel && bus_addr == 12'h098;
    acc = core_pwr && !dbl_lock && !os_lock;
    for (int v = 0; v < 2; v++) begin
      exp_rd[v] = (sel && acc) ? m_reg[v] : 32'h0;
      nx_reg[v] = m_reg[v];
      if (sel && acc && bus_wr && !sw_lock)
        nx_reg[v] = bus_wdata & (v == 0 ? 32'hFFFF : 32'hFF);
      nx_cp[v] = warm_rst_n && ev_valid &&
                 fires(m_reg[v], v == 0, v == 0, ev_kind, ev_level, ev_secure);
    end
    check(rd_f == exp_rd[0], "full rdata", rd_f, exp_rd[0]);
    check(rd_r == exp_rd[1], "reduced rdata", rd_r, exp_rd[1]);
    check(err_f == (sel && !acc), "full err", 32'(err_f), 32'(sel && !acc));
    check(err_r == (sel && !acc), "reduced err", 32'(err_r), 32'(sel && !acc));
    @(posedge clk);
    for (int v = 0; v < 2; v++) begin
      m_reg[v] = cold_rst_n ? nx_reg[v] : 32'h0;
      m_cp[v]  = cold_rst_n ? nx_cp[v] : 1'b0;
    end
    @(negedge clk);
    check(cp_f == m_cp[0], "full catch", 32'(cp_f), 32'(m_cp[0]));
    check(cp_r == m_cp[1], "reduced catch", 32'(cp_r), 32'(m_cp[1]));
  endtask

  task automatic idle();
    bus_sel = 0; bus_wr = 0; bus_addr = 12'h098; bus_wdata = 0;
    ev_valid = 0; ev_kind = 0; ev_level = 0; ev_secure = 0;
  endtask

  task automatic acc_op(bit wr, logic [11:0] a, logic [31:0] d);
    idle(); bus_sel = 1; bus_wr = wr; bus_addr = a; bus_wdata = d;
    tick(); idle();
  endtask

  task automatic ev(logic [1:0] k, logic [1:0] l, bit s);
    idle(); ev_valid = 1; ev_kind = k; ev_level = l; ev_secure = s;
    tick(); idle();
  endtask

  initial begin
    #150000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    m_reg[0] = 0; m_reg[1] = 0; m_cp[0] = 0; m_cp[1] = 0;
    idle();
    cold_rst_n = 0; warm_rst_n = 1; core_pwr = 1; dbl_lock = 0; os_lock = 0; sw_lock = 0;
    @(negedge clk); @(negedge clk);
    cold_rst_n = 1;
    cur_req = "R13"; acc_op(0, 12'h098, 0);
    cur_req = "R1";  acc_op(1, 12'h098, 32'hFFFF_FFFF); acc_op(0, 12'h098, 0);
    acc_op(1, 12'h098, 32'hA5C3_5A3C); acc_op(0, 12'h098, 0);
    cur_req = "R9";  acc_op(1, 12'h098, 32'h0000_F00F); acc_op(0, 12'h098, 0);
    for (int l = 0; l < 4; l++) for (int k = 0; k < 4; k++) begin
      ev(2'(k), 2'(l), 1); ev(2'(k), 2'(l), 0);
    end
    cur_req = "R4";
    acc_op(1, 12'h09C, 32'h1234); acc_op(1, 12'h094, 32'h0); acc_op(0, 12'h099, 0);
    idle(); bus_sel = 0; bus_wr = 1; bus_wdata = 32'h0; tick(); idle();
    acc_op(0, 12'h098, 0);
    cur_req = "R2";
    core_pwr = 0; acc_op(1, 12'h098, 32'h1); acc_op(0, 12'h098, 0); core_pwr = 1;
    dbl_lock = 1; acc_op(1, 12'h098, 32'h2); acc_op(0, 12'h098, 0); dbl_lock = 0;
    os_lock = 1;  acc_op(1, 12'h098, 32'h3); acc_op(0, 12'h098, 0); os_lock = 0;
    acc_op(0, 12'h098, 0);
    cur_req = "R3";
    sw_lock = 1; acc_op(1, 12'h098, 32'h0); acc_op(0, 12'h098, 0); sw_lock = 0;
    acc_op(0, 12'h098, 0);
    for (int s = 0; s < 2; s++) for (int l = 0; l < 4; l++) for (int p = 0; p < 4; p++) begin
      logic [31:0] w;
      w = 0;
      if (p[1]) w[(s ? 0 : 4) + l] = 1'b1;
      if (p[0]) w[(s ? 8 : 12) + l] = 1'b1;
      case (p)
        0: cur_req = "R5";
        1: cur_req = "R6";
        2: cur_req = "R7";
        default: cur_req = "R8";
      endcase
      if (l == 3) cur_req = "R10";
      acc_op(1, 12'h098, w);
      for (int k = 0; k < 4; k++) begin
        if (k == 1) cur_req = (l == 3) ? "R10" : "R11";
        ev(2'(k), 2'(l), s[0]);
        ev(2'(k), 2'(l), !s[0]);
      end
    end
    cur_req = "R12";
    acc_op(1, 12'h098, 32'h0000_FFFF);
    ev_valid = 1; ev_kind = 0; ev_level = 1; ev_secure = 0; tick();
    tick(); idle(); tick();
    ev_valid = 0; ev_kind = 0; ev_level = 0; tick(); tick();
    cur_req = "R13";
    acc_op(1, 12'h098, 32'h0000_0033);
    ev_valid = 1; ev_kind = 0; ev_level = 0; ev_secure = 1; warm_rst_n = 0; tick();
    warm_rst_n = 1; idle(); acc_op(0, 12'h098, 0);
    ev(0, 0, 1);
    cold_rst_n = 0; tick(); cold_rst_n = 1;
    acc_op(0, 12'h098, 0); ev(0, 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule